// File: doc/BRIEF.md
# Asynchronous EPROM Read Controller

This block sits between a synchronous system and an asynchronous, byte-wide, 32768-location read-only memory that has separate chip-select and output-gate pins, both active low. The system raises a request with a 15-bit address. The controller then drives the address and both enables, and waits a fixed number of clock cycles. That wait is worked out at elaboration time from the clock period and the memory's speed grade. The controller then captures the 8-bit data bus and hands the byte back with a single-cycle valid pulse.

The wait honours three separate access limits: the limit from address, the limit from chip select, and the limit from output gate. The output gate may be held back after chip select by a parameterised number of cycles. This lag is clamped so that it never lengthens the access. One margin cycle is added before capture. Chip select and output gate are released together on the capture edge, because the memory's data hold time is zero. After release, the controller stays busy for a float gap that covers the time the memory's outputs take to go high impedance. This ensures that two memories sharing the bus never drive it at the same time.

Top module: `eprom_read_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `mem_ce_n` and `mem_oe_n` are 1 and `busy` and `rvalid` are 0.
- R2: When `req` is 1 and `busy` is 0 at a clock edge, the request is accepted. After that edge, `mem_addr` equals the sampled `addr`, `mem_ce_n` is 0 and `busy` is 1. `busy` is 1 whenever `mem_ce_n` is 0.
- R3: `mem_oe_n` falls a lag of L cycles after `mem_ce_n` falls, where L is `OE_LAG` clamped to CE-wait minus OE-wait. With L = 0 it falls on the same edge as `mem_ce_n`. `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R4: Let the acceptance edge be E. Data is captured at edge E+S, with S = max(address wait, CE wait, L + OE wait) + 1. After that edge `rdata` holds the value `mem_data` had just before it, and `rvalid` is 1 for exactly one cycle.
- R5: `mem_ce_n` and `mem_oe_n` rise together on the capture edge.
- R6: From acceptance to capture, `mem_addr` does not change and `mem_ce_n` stays 0.
- R7: After release, `busy` stays 1 for F cycles, where F is the float wait. `mem_ce_n` is therefore high for more than F cycles before it can fall again.
- R8: A `req` seen while `busy` is 1 is ignored. It starts no access and leaves `mem_addr` unchanged.
- R9: Each wait is ceil(time / `CLK_PERIOD_NS`). `SPEED_GRADE` 0, 1 and 2 select address and CE times of 200, 250 and 300 ns, and OE times of 100, 125 and 125 ns. The float time is 50 ns, with a float wait of at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Read request, sampled when not busy |
| addr | input | 15 | Byte address for the request |
| busy | output | 1 | Access or float gap in progress |
| rdata | output | 8 | Captured byte |
| rvalid | output | 1 | One-cycle pulse: rdata is new |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_data | input | 8 | Data bus from the memory |

## Verification
The assertions cover the properties that hold on every cycle: the reset state, and that the output gate is low only under chip select. They also check that both enables rise together with the valid pulse and that the pulse lasts a single cycle. Other per-cycle checks are that the address is frozen while the controller is busy and that the high time before each new chip select exceeds the float wait. The exact capture cycle, the lagged output-gate edge and the captured byte can only be shown by the bench's scenarios. The bench runs a behavioural reference against two configurations, one fast grade without lag and one slow grade with maximum lag. Its memory model returns the wrong byte whenever any of the three access limits, plus margin, has not yet elapsed.

// File: rtl/erc_pkg.sv
// Package: shared state type and timing helpers for the EPROM read controller.
// Assumes all times are integer nanoseconds and the clock period is nonzero.
package erc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } erc_state_e;

    localparam int unsigned FLOAT_NS = 50;

    // Round a time up to whole clock cycles.
    function automatic int unsigned ceil_cycles(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Address-to-data and select-to-data time for a speed grade.
    function automatic int unsigned grade_acc_ns(input int unsigned grade);
        case (grade)
            0:       return 200;
            1:       return 250;
            default: return 300;
        endcase
    endfunction

    // Output-gate-to-data time for a speed grade.
    function automatic int unsigned grade_oe_ns(input int unsigned grade);
        return (grade == 0) ? 100 : 125;
    endfunction

endpackage

// File: rtl/erc_timer.sv
// Module: cycle counter shared by the access and float phases.
// Restart loads 1 (the first elapsed cycle); run counts up otherwise.
// Assumes the sequencer restarts it before the count can wrap.
module erc_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    output logic [CNT_W-1:0] count
);

    // Count elapsed cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= CNT_W'(1);
        end else if (run) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/erc_seq.sv
// Module: sequencer for one read: accept, assert enables, wait, capture,
// release, then hold busy through the float gap.
// Assumes LAG_CYC < SAMPLE_CYC and OFF_CYC >= 1, as the top computes.
module erc_seq
    import erc_pkg::*;
#(
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned SAMPLE_CYC = 11,
    parameter int unsigned LAG_CYC    = 0,
    parameter int unsigned OFF_CYC    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] count,
    output logic             accept,
    output logic             capture,
    output logic             restart,
    output logic             run,
    output logic             busy,
    output logic             ce_n,
    output logic             oe_n
);

    erc_state_e state_q, state_d;
    logic       oe_fall;
    logic       float_done;

    // Phase events decoded from state and the cycle count.
    always_comb begin
        accept     = (state_q == ST_IDLE) && req;
        capture    = (state_q == ST_ACCESS) && (count == CNT_W'(SAMPLE_CYC));
        float_done = (state_q == ST_FLOAT) && (count == CNT_W'(OFF_CYC));
        restart    = accept || capture;
        run        = (state_q != ST_IDLE);
        busy       = (state_q != ST_IDLE);
    end

    // Late output-gate edge only exists when a lag is configured.
    generate
        if (LAG_CYC == 0) begin : g_no_lag
            assign oe_fall = 1'b0;
        end else begin : g_lag
            assign oe_fall = (state_q == ST_ACCESS) && (count == CNT_W'(LAG_CYC));
        end
    endgenerate

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept)     state_d = ST_ACCESS;
            ST_ACCESS: if (capture)    state_d = ST_FLOAT;
            ST_FLOAT:  if (float_done) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered enables: fall on accept (gate possibly later), rise on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n <= 1'b1;
            oe_n <= 1'b1;
        end else if (accept) begin
            ce_n <= 1'b0;
            oe_n <= (LAG_CYC != 0);
        end else if (capture) begin
            ce_n <= 1'b1;
            oe_n <= 1'b1;
        end else if (oe_fall) begin
            oe_n <= 1'b0;
        end
    end

endmodule

// File: rtl/erc_capture.sv
// Module: address latch toward the memory and the returned data register.
// Assumes accept and capture are never high together.
module erc_capture #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    // Hold the accepted address for the whole access and float gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
        end else if (accept) begin
            mem_addr <= addr_in;
        end
    end

    // Capture the bus on the release edge and pulse valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= mem_data;
            end
        end
    end

endmodule

// File: rtl/eprom_read_ctrl.sv
// Module: top of the asynchronous EPROM read controller.
// Derives all wait counts from the clock period and speed grade, then
// connects the timer, sequencer and capture register.
// Assumes mem_data comes straight from the memory pins; the extra
// margin cycle covers the input path.
module eprom_read_ctrl
    import erc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 15,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter int unsigned OE_LAG        = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_data
);

    localparam int unsigned ACC_CYC    = ceil_cycles(grade_acc_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned CE_CYC     = ceil_cycles(grade_acc_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned OE_CYC     = ceil_cycles(grade_oe_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned OFF_RAW    = ceil_cycles(FLOAT_NS, CLK_PERIOD_NS);
    localparam int unsigned OFF_CYC    = (OFF_RAW == 0) ? 1 : OFF_RAW;
    localparam int unsigned LAG_MAX    = (CE_CYC > OE_CYC) ? (CE_CYC - OE_CYC) : 0;
    localparam int unsigned LAG_CYC    = (OE_LAG > LAG_MAX) ? LAG_MAX : OE_LAG;
    localparam int unsigned DATA_CYC   = max2(max2(ACC_CYC, CE_CYC), LAG_CYC + OE_CYC);
    localparam int unsigned SAMPLE_CYC = DATA_CYC + 1;
    localparam int unsigned CNT_W      = $clog2(max2(SAMPLE_CYC, OFF_CYC) + 1);

    logic             accept;
    logic             capture;
    logic             restart;
    logic             run;
    logic [CNT_W-1:0] count;

    erc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run),
        .count   (count)
    );

    erc_seq #(
        .CNT_W      (CNT_W),
        .SAMPLE_CYC (SAMPLE_CYC),
        .LAG_CYC    (LAG_CYC),
        .OFF_CYC    (OFF_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .count   (count),
        .accept  (accept),
        .capture (capture),
        .restart (restart),
        .run     (run),
        .busy    (busy),
        .ce_n    (mem_ce_n),
        .oe_n    (mem_oe_n)
    );

    erc_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .addr_in  (addr),
        .mem_data (mem_data),
        .mem_addr (mem_addr),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

endmodule

// File: rtl/eprom_read_ctrl_chk.sv
// Module: property checker bound to eprom_read_ctrl; observes ports only
// plus a local counter of chip-select high time.
module eprom_read_ctrl_chk #(
    parameter int unsigned ADDR_W  = 15,
    parameter int unsigned OFF_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n
);

    logic [15:0] high_cnt;

    // Cycles chip select has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= 16'hFFFF;
        end else if (!mem_ce_n) begin
            high_cnt <= '0;
        end else if (high_cnt != 16'hFFFF) begin
            high_cnt <= high_cnt + 16'd1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && mem_oe_n && !busy && !rvalid));

    a_r2_busy_under_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> busy);

    a_r3_gate_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    a_r4_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $rose(mem_ce_n));

    a_r5_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> $rose(mem_oe_n));

    a_r5_gate_rises_with_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> $rose(mem_ce_n));

    a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r7_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (high_cnt > 16'(OFF_CYC)));

    a_r8_busy_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_addr));

endmodule

bind eprom_read_ctrl eprom_read_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .OFF_CYC (OFF_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rvalid   (rvalid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n)
);

// File: tb/eprom_read_ctrl_tb.sv
package erc_tb_pkg;
    function automatic int cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction
    function automatic int t_acc(input int g);
        return (g == 0) ? 200 : ((g == 1) ? 250 : 300);
    endfunction
    function automatic int t_oe(input int g);
        return (g == 0) ? 100 : 125;
    endfunction
    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction
endpackage

// Memory model: returns the byte only once every limit plus margin has elapsed.
module erc_tb_mem #(parameter int GRADE = 0, parameter int PERIOD = 20) (
    input  logic        clk,
    input  logic [14:0] mem_addr,
    input  logic        ce_n,
    input  logic        oe_n,
    output logic [7:0]  mem_data
);
    import erc_tb_pkg::*;
    localparam int NA = cyc(t_acc(GRADE), PERIOD);
    localparam int NO = cyc(t_oe(GRADE), PERIOD);
    int ce_cnt = 0;
    int oe_cnt = 0;
    int a_cnt  = 0;
    logic [14:0] last_a = '0;
    always @(negedge clk) begin
        ce_cnt = ce_n ? 0 : ce_cnt + 1;
        oe_cnt = oe_n ? 0 : oe_cnt + 1;
        if (mem_addr !== last_a) begin
            last_a = mem_addr;
            a_cnt  = 1;
        end else begin
            a_cnt = a_cnt + 1;
        end
    end
    assign mem_data = (ce_cnt > NA && oe_cnt > NO && a_cnt > NA) ? pat(mem_addr) : ~pat(mem_addr);
endmodule

// Behavioural reference of the expected port values, updated per clock.
module erc_tb_ref #(parameter int GRADE = 0, parameter int PERIOD = 20, parameter int LAG = 0) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [14:0] addr,
    output logic        e_ce_n,
    output logic        e_oe_n,
    output logic        e_busy,
    output logic        e_rvalid,
    output logic [7:0]  e_rdata,
    output logic [14:0] e_addr
);
    import erc_tb_pkg::*;
    localparam int NA   = cyc(t_acc(GRADE), PERIOD);
    localparam int NO   = cyc(t_oe(GRADE), PERIOD);
    localparam int LMAX = (NA > NO) ? NA - NO : 0;
    localparam int LE   = (LAG > LMAX) ? LMAX : LAG;
    localparam int S    = ((NA > LE + NO) ? NA : LE + NO) + 1;
    localparam int F    = (cyc(50, PERIOD) < 1) ? 1 : cyc(50, PERIOD);
    int st  = 0;
    int cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            st = 0; cnt = 0;
            e_ce_n = 1; e_oe_n = 1; e_busy = 0; e_rvalid = 0;
            e_rdata = '0; e_addr = '0;
        end else begin
            e_rvalid = 0;
            if (st == 0) begin
                if (req) begin
                    st = 1; cnt = 1; e_addr = addr;
                    e_ce_n = 0; e_oe_n = (LE != 0);
                end
            end else if (st == 1) begin
                if (LE != 0 && cnt == LE) e_oe_n = 0;
                if (cnt == S) begin
                    e_rvalid = 1; e_rdata = pat(e_addr);
                    e_ce_n = 1; e_oe_n = 1; st = 2; cnt = 1;
                end else begin
                    cnt = cnt + 1;
                end
            end else begin
                if (cnt == F) st = 0;
                else cnt = cnt + 1;
            end
            e_busy = (st != 0);
        end
    end
endmodule

module eprom_read_ctrl_tb;
    import erc_tb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [14:0] addr = '0;
    int          n_total = 0;
    int          n_fail = 0;
    bit          cmp_en = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    // Fast grade, no lag.
    logic        a_busy, a_rvalid, a_ce_n, a_oe_n;
    logic [7:0]  a_rdata, a_mdata;
    logic [14:0] a_maddr;
    eprom_read_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(a_busy),
        .rdata(a_rdata), .rvalid(a_rvalid), .mem_addr(a_maddr),
        .mem_ce_n(a_ce_n), .mem_oe_n(a_oe_n), .mem_data(a_mdata));
    erc_tb_mem #(.GRADE(0), .PERIOD(20)) u_mem_a (
        .clk(clk), .mem_addr(a_maddr), .ce_n(a_ce_n), .oe_n(a_oe_n), .mem_data(a_mdata));
    logic        ea_ce_n, ea_oe_n, ea_busy, ea_rvalid;
    logic [7:0]  ea_rdata;
    logic [14:0] ea_addr;
    erc_tb_ref #(.GRADE(0), .PERIOD(20), .LAG(0)) u_ref_a (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .e_ce_n(ea_ce_n), .e_oe_n(ea_oe_n),
        .e_busy(ea_busy), .e_rvalid(ea_rvalid), .e_rdata(ea_rdata), .e_addr(ea_addr));

    // Slowest grade, output gate lagged by the largest allowed amount (R3, R9).
    logic        b_busy, b_rvalid, b_ce_n, b_oe_n;
    logic [7:0]  b_rdata, b_mdata;
    logic [14:0] b_maddr;
    eprom_read_ctrl #(.SPEED_GRADE(2), .OE_LAG(8)) u_dut_lag (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(b_busy),
        .rdata(b_rdata), .rvalid(b_rvalid), .mem_addr(b_maddr),
        .mem_ce_n(b_ce_n), .mem_oe_n(b_oe_n), .mem_data(b_mdata));
    erc_tb_mem #(.GRADE(2), .PERIOD(20)) u_mem_b (
        .clk(clk), .mem_addr(b_maddr), .ce_n(b_ce_n), .oe_n(b_oe_n), .mem_data(b_mdata));
    logic        eb_ce_n, eb_oe_n, eb_busy, eb_rvalid;
    logic [7:0]  eb_rdata;
    logic [14:0] eb_addr;
    erc_tb_ref #(.GRADE(2), .PERIOD(20), .LAG(8)) u_ref_b (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .e_ce_n(eb_ce_n), .e_oe_n(eb_oe_n),
        .e_busy(eb_busy), .e_rvalid(eb_rvalid), .e_rdata(eb_rdata), .e_addr(eb_addr));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R2 R6 dut_a ce_n", 32'(a_ce_n), 32'(ea_ce_n));
            check("R3 R5 dut_a oe_n", 32'(a_oe_n), 32'(ea_oe_n));
            check("R2 R7 dut_a busy", 32'(a_busy), 32'(ea_busy));
            check("R4 R9 dut_a rvalid", 32'(a_rvalid), 32'(ea_rvalid));
            if (ea_rvalid) check("R4 dut_a rdata", 32'(a_rdata), 32'(ea_rdata));
            if (!ea_ce_n)  check("R6 R8 dut_a mem_addr", 32'(a_maddr), 32'(ea_addr));
            check("R2 R6 dut_lag ce_n", 32'(b_ce_n), 32'(eb_ce_n));
            check("R3 R5 dut_lag oe_n", 32'(b_oe_n), 32'(eb_oe_n));
            check("R2 R7 dut_lag busy", 32'(b_busy), 32'(eb_busy));
            check("R4 R9 dut_lag rvalid", 32'(b_rvalid), 32'(eb_rvalid));
            if (eb_rvalid) check("R4 dut_lag rdata", 32'(b_rdata), 32'(eb_rdata));
            if (!eb_ce_n)  check("R6 R8 dut_lag mem_addr", 32'(b_maddr), 32'(eb_addr));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        cycles(4);
        // R1: reset state at the ports
        check("R1 dut_a idle outputs", {28'd0, a_ce_n, a_oe_n, a_busy, a_rvalid}, 32'hC);
        check("R1 dut_lag idle outputs", {28'd0, b_ce_n, b_oe_n, b_busy, b_rvalid}, 32'hC);
        rst_n = 1'b1;
        cmp_en = 1;
        cycles(3);

        // Single reads at the address extremes.
        addr = 15'h0000; req = 1'b1; cycles(1); req = 1'b0; cycles(40);
        addr = 15'h7FFF; req = 1'b1; cycles(1); req = 1'b0;

        // R8: request pulse while busy must start nothing.
        cycles(3);
        addr = 15'h1234; req = 1'b1; cycles(1); req = 1'b0;
        cycles(40);
        check("R8 dut_a no extra access", {30'd0, a_ce_n, a_busy}, 32'h2);
        check("R8 dut_lag no extra access", {30'd0, b_ce_n, b_busy}, 32'h2);
        check("R8 dut_a addr kept", 32'(a_maddr), 32'h7FFF);
        check("R8 dut_lag addr kept", 32'(b_maddr), 32'h7FFF);

        // Back-to-back reads with req held and the address changing.
        req = 1'b1;
        for (int i = 0; i < 150; i++) begin
            addr = (i[0]) ? 15'h5555 : 15'h2AAA ^ 15'(i);
            cycles(1);
        end
        req = 1'b0;
        cycles(30);

        // Pseudo-random requests and addresses.
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req  = lfsr[0] & lfsr[3];
            addr = lfsr[14:0];
            cycles(1);
        end
        req = 1'b0;
        cycles(40);

        // R7: everything returns to idle after the last float gap.
        check("R7 dut_a idle at end", {30'd0, a_ce_n, a_busy}, 32'h2);
        check("R7 dut_lag idle at end", {30'd0, b_ce_n, b_busy}, 32'h2);

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule